// File: doc/BRIEF.md
# Inductive Coupling Legality Checker

This block decides whether a proposed set of pin transitions on one bus segment may be launched off-chip in a single cycle. Each signal pin carries a three-valued transition code: rising, falling or static. The checker models signed mutual coupling from neighbours up to a chosen distance. The reach crosses into the signal pins of the segments on either side. From this it judges each signal pin against the rule for its own direction: a glitch window when static, or a minimum helpful coupling when switching. It also bounds how many signals switch the same way through the segment's supply and ground pins.

A segment is laid out as one supply pin, `SIG_W` signal pins, and one ground pin. Adjacent segments repeat that layout. An encoder that inserts stutter states calls this block on each candidate step. Each valid request yields a registered verdict one cycle later. The verdict is a legal flag plus a mask that names every broken constraint. Weights, thresholds, reach and accumulator width are integer parameters.

Top module: `cpl_couple_chk`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `vld_o`=0, `legal_o`=1 and `viol_o`=0.
- R2: Each pin uses two bits of its bus; pin s sits at bits [2s+1:2s], and pin 0 is next to the segment's supply pin. Code 00 means static (value 0), 01 means rising (+1), 11 means falling (-1), and the unused code 10 behaves exactly like static.
- R3: A static signal pin violates its static constraint unless its coupling sum S satisfies -P0 < S < P0.
- R4: A rising signal pin violates its rising constraint unless S > P1; a falling signal pin violates its falling constraint unless S < PM1.
- R5: The supply constraint is violated unless Z × (number of rising signal pins) < 2 × PBNC. The ground constraint is violated unless Z × (number of falling signal pins) < 2 × PBNC.
- R6: S is the sum, over q = 1..REACH, of KWT[q-1] × (value of the pin q places left + value of the pin q places right). This uses the concatenated left segment, own segment and right segment. Supply and ground pins contribute 0, and signals of `lft_i`/`rgt_i` count when within reach.
- R7: Before comparison, S is clamped to the signed range of ACC_W bits, [-2^(ACC_W-1), 2^(ACC_W-1)-1].
- R8: Bit 0 of `viol_o` is the supply constraint. Bits 3s+1, 3s+2 and 3s+3 are the rising, falling and static constraints of signal pin s. Bit 3·SIG_W+1 is ground. `legal_o` is 1 exactly when the mask is 0.
- R9: A request with `vld_i`=1 yields its result and `vld_o`=1 on the following rising edge. While `vld_i`=0, `legal_o` and `viol_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Request qualifier |
| seg_i | input | 2*SIG_W | Transition codes of the segment under test |
| lft_i | input | 2*SIG_W | Transition codes of the left neighbour segment's signals |
| rgt_i | input | 2*SIG_W | Transition codes of the right neighbour segment's signals |
| vld_o | output | 1 | Result qualifier, one cycle after `vld_i` |
| legal_o | output | 1 | High when no constraint is violated |
| viol_o | output | 3*SIG_W+2 | Per-constraint violation mask |

## Verification
The hardest case to reach is clamping of the coupling sum. With the default weights and width, no port pattern can drive a sum out of range, so saturation never changes a verdict. The bench therefore adds a second instance with large weights and a narrow accumulator. It drives a static pin flanked by two rising pins, whose true sum reaches the glitch limit exactly while the clamped sum stays below it. Cross-segment reach is reached by pairing an own-segment aggressor with a left or right neighbour signal that tips a static pin over its limit.

// File: rtl/cpl_pkg.sv
// Shared types and helpers for the coupling checker.
// Assumes two-bit transition codes; code 10 is folded into static.
package cpl_pkg;
    typedef logic [1:0] trit_t;

    localparam trit_t TR_STAT = 2'b00;
    localparam trit_t TR_RISE = 2'b01;
    localparam trit_t TR_FALL = 2'b11;

    // Signed value of a transition code.
    function automatic int trit_val(input trit_t t);
        case (t)
            TR_RISE: return 1;
            TR_FALL: return -1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/cpl_wsum.sv
// Distance-weighted signed coupling sum for one victim position.
// Assumes the pin vector holds 3*NPIN pins and VICTIM +/- REACH stays in range.
module cpl_wsum
    import cpl_pkg::*;
#(
    parameter int unsigned NPIN   = 5,
    parameter int unsigned REACH  = 3,
    parameter int          KWT [REACH] = '{3, 1, 1},
    parameter int unsigned ACC_W  = 8,
    parameter int unsigned VICTIM = 6
) (
    input  logic [6*NPIN-1:0]        pins_i,
    output logic signed [ACC_W-1:0]  sum_o
);
    localparam int SMAX = (1 << (ACC_W - 1)) - 1;
    localparam int SMIN = -(1 << (ACC_W - 1));

    int acc;

    // Accumulate exactly, then clamp to the accumulator range.
    always_comb begin
        acc = 0;
        for (int q = 1; q <= int'(REACH); q++) begin
            acc = acc + KWT[q-1] * (trit_val(pins_i[2*(VICTIM+q) +: 2])
                                  + trit_val(pins_i[2*(VICTIM-q) +: 2]));
        end
        if (acc > SMAX)      sum_o = ACC_W'(SMAX);
        else if (acc < SMIN) sum_o = ACC_W'(SMIN);
        else                 sum_o = ACC_W'(acc);
    end
endmodule

// File: rtl/cpl_pin_rule.sv
// Applies the direction-dependent rule to one signal pin.
// Output bit 0 rising, bit 1 falling, bit 2 static; only the rule
// matching the pin's own direction can fire.
module cpl_pin_rule
    import cpl_pkg::*;
#(
    parameter int unsigned ACC_W = 8,
    parameter int          P0    = 4,
    parameter int          P1    = -4,
    parameter int          PM1   = 4
) (
    input  trit_t                   dir_i,
    input  logic signed [ACC_W-1:0] sum_i,
    output logic [2:0]              viol_o
);
    int s;

    // Select and evaluate the rule for this pin's direction.
    always_comb begin
        s      = int'(sum_i);
        viol_o = 3'b000;
        case (dir_i)
            TR_RISE: viol_o[0] = !(s > P1);
            TR_FALL: viol_o[1] = !(s < PM1);
            default: viol_o[2] = !((s > -P0) && (s < P0));
        endcase
    end
endmodule

// File: rtl/cpl_bounce.sv
// Supply and ground bounce limits from same-direction switching counts.
// Uses Z*count < 2*PBNC so the half factor needs no division.
module cpl_bounce
    import cpl_pkg::*;
#(
    parameter int unsigned SIG_W = 3,
    parameter int          Z     = 2,
    parameter int          PBNC  = 3
) (
    input  logic [2*SIG_W-1:0] seg_i,
    output logic               sup_viol_o,
    output logic               gnd_viol_o
);
    localparam int CNT_W = $clog2(SIG_W + 1);

    logic [CNT_W-1:0] n_rise;
    logic [CNT_W-1:0] n_fall;

    // Count rising and falling signal pins.
    always_comb begin
        n_rise = '0;
        n_fall = '0;
        for (int s = 0; s < int'(SIG_W); s++) begin
            if (seg_i[2*s +: 2] == TR_RISE) n_rise = n_rise + 1'b1;
            if (seg_i[2*s +: 2] == TR_FALL) n_fall = n_fall + 1'b1;
        end
    end

    // Compare scaled counts against the bounce budget.
    always_comb begin
        sup_viol_o = !((Z * int'(n_rise)) < (2 * PBNC));
        gnd_viol_o = !((Z * int'(n_fall)) < (2 * PBNC));
    end
endmodule

// File: rtl/cpl_couple_chk.sv
// Top of the coupling legality checker. Builds the three-segment pin
// vector, instantiates one sum and rule per signal pin plus the bounce
// unit, and registers the verdict. Assumes REACH <= SIG_W + 2.
module cpl_couple_chk
    import cpl_pkg::*;
#(
    parameter int unsigned SIG_W = 3,
    parameter int unsigned REACH = 3,
    parameter int          KWT [REACH] = '{3, 1, 1},
    parameter int unsigned ACC_W = 8,
    parameter int          P0    = 4,
    parameter int          P1    = -4,
    parameter int          PM1   = 4,
    parameter int          Z     = 2,
    parameter int          PBNC  = 3,
    localparam int unsigned NCON = 3 * SIG_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  logic [2*SIG_W-1:0] seg_i,
    input  logic [2*SIG_W-1:0] lft_i,
    input  logic [2*SIG_W-1:0] rgt_i,
    output logic               vld_o,
    output logic               legal_o,
    output logic [NCON-1:0]    viol_o
);
    localparam int unsigned NPIN = SIG_W + 2;

    logic [6*NPIN-1:0] pins;
    logic [NCON-1:0]   mask;
    logic              sup_v;
    logic              gnd_v;

    // Lay out left, own and right segments; rails contribute static.
    always_comb begin
        pins = '0;
        for (int s = 0; s < int'(SIG_W); s++) begin
            pins[2*(1 + s)            +: 2] = lft_i[2*s +: 2];
            pins[2*(NPIN + 1 + s)     +: 2] = seg_i[2*s +: 2];
            pins[2*(2*NPIN + 1 + s)   +: 2] = rgt_i[2*s +: 2];
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(SIG_W); g++) begin : g_pin
            logic signed [ACC_W-1:0] sum;
            logic [2:0]              pv;

            cpl_wsum #(
                .NPIN(NPIN), .REACH(REACH), .KWT(KWT),
                .ACC_W(ACC_W), .VICTIM(NPIN + 1 + g)
            ) u_sum (
                .pins_i(pins),
                .sum_o (sum)
            );

            cpl_pin_rule #(
                .ACC_W(ACC_W), .P0(P0), .P1(P1), .PM1(PM1)
            ) u_rule (
                .dir_i (seg_i[2*g +: 2]),
                .sum_i (sum),
                .viol_o(pv)
            );

            assign mask[3*g + 1 +: 3] = pv;
        end
    endgenerate

    cpl_bounce #(.SIG_W(SIG_W), .Z(Z), .PBNC(PBNC)) u_bnc (
        .seg_i     (seg_i),
        .sup_viol_o(sup_v),
        .gnd_viol_o(gnd_v)
    );

    assign mask[0]      = sup_v;
    assign mask[NCON-1] = gnd_v;

    // Register the verdict on valid requests; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            legal_o <= 1'b1;
            viol_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                legal_o <= ~|mask;
                viol_o  <= mask;
            end
        end
    end
endmodule

// File: rtl/cpl_couple_chk_sva.sv
// Checker for cpl_couple_chk: reset values, valid timing, hold,
// quiet-bus legality and per-pin mask consistency.
module cpl_couple_chk_sva #(
    parameter int unsigned SIG_W = 3,
    parameter int          P0    = 4,
    localparam int unsigned NCON = 3 * SIG_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vld_i,
    input logic [2*SIG_W-1:0] seg_i,
    input logic [2*SIG_W-1:0] lft_i,
    input logic [2*SIG_W-1:0] rgt_i,
    input logic               vld_o,
    input logic               legal_o,
    input logic [NCON-1:0]    viol_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!vld_o && legal_o && viol_o == '0)); // R1

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !vld_i) |=> ($stable(viol_o) && $stable(legal_o))); // R9

    AST_QUIET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && P0 > 0 && seg_i == '0 && lft_i == '0 && rgt_i == '0)
        |=> legal_o); // R3

    AST_LEGAL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (legal_o == (viol_o == '0))); // R8

    genvar g;
    generate
        for (g = 0; g < int'(SIG_W); g++) begin : g_one
            AST_ONE_RULE_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(viol_o[3*g + 1 +: 3]) <= 1); // R8
        end
    endgenerate
endmodule

bind cpl_couple_chk cpl_couple_chk_sva #(.SIG_W(SIG_W), .P0(P0)) u_sva (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .seg_i(seg_i),
    .lft_i(lft_i), .rgt_i(rgt_i), .vld_o(vld_o),
    .legal_o(legal_o), .viol_o(viol_o)
);

// File: tb/sim_cpl_couple_chk.sv
// Scoreboard bench: the driver pushes expected masks for two instances
// (default and saturating), the monitor pops and compares results.
module sim_cpl_couple_chk;
    localparam int SW   = 3;
    localparam int NP   = SW + 2;
    localparam int NC   = 3 * SW + 2;
    localparam int P0   = 4;
    localparam int P1   = -4;
    localparam int PM1  = 4;
    localparam int ZV   = 2;
    localparam int PB   = 3;

    typedef struct {
        logic [NC-1:0] m0;
        logic [NC-1:0] m1;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld_i = 1'b0;
    logic [2*SW-1:0] seg_i = '0, lft_i = '0, rgt_i = '0;
    logic          vld0, leg0, vld1, leg1;
    logic [NC-1:0] vio0, vio1;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    cpl_couple_chk #(.SIG_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .seg_i(seg_i),
        .lft_i(lft_i), .rgt_i(rgt_i), .vld_o(vld0), .legal_o(leg0), .viol_o(vio0)
    );

    cpl_couple_chk #(.SIG_W(SW), .KWT('{20, 15, 5}), .ACC_W(6), .P0(40)) u1 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .seg_i(seg_i),
        .lft_i(lft_i), .rgt_i(rgt_i), .vld_o(vld1), .legal_o(leg1), .viol_o(vio1)
    );

    function automatic int tv(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    // Reference verdict from the requirement text.
    function automatic logic [NC-1:0] ref_mask(
        input logic [2*SW-1:0] s, input logic [2*SW-1:0] l, input logic [2*SW-1:0] r,
        input int k0, input int k1, input int k2, input int accw, input int p0);
        int v [3*NP];
        int kw [3];
        logic [NC-1:0] m;
        int nr, nf, sum, hi, lo;
        kw[0] = k0; kw[1] = k1; kw[2] = k2;
        for (int i = 0; i < 3*NP; i++) v[i] = 0;
        for (int i = 0; i < SW; i++) begin
            v[1 + i]        = tv(l[2*i +: 2]);
            v[NP + 1 + i]   = tv(s[2*i +: 2]);
            v[2*NP + 1 + i] = tv(r[2*i +: 2]);
        end
        hi = (1 << (accw - 1)) - 1;
        lo = -(1 << (accw - 1));
        m = '0; nr = 0; nf = 0;
        for (int i = 0; i < SW; i++) begin
            int c;
            c = NP + 1 + i;
            sum = 0;
            for (int q = 1; q <= 3; q++) sum += kw[q-1] * (v[c-q] + v[c+q]);
            if (sum > hi) sum = hi;
            if (sum < lo) sum = lo;
            if (v[c] == 1) begin
                nr++;
                m[3*i + 1] = !(sum > P1);
            end else if (v[c] == -1) begin
                nf++;
                m[3*i + 2] = !(sum < PM1);
            end else begin
                m[3*i + 3] = !((sum > -p0) && (sum < p0));
            end
        end
        m[0]    = !(ZV * nr < 2 * PB);
        m[NC-1] = !(ZV * nf < 2 * PB);
        return m;
    endfunction

    task automatic check(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: apply one request and push its expectation.
    task automatic drive(input string tag, input logic [2*SW-1:0] s,
                         input logic [2*SW-1:0] l, input logic [2*SW-1:0] r);
        exp_t e;
        @(negedge clk);
        seg_i = s; lft_i = l; rgt_i = r; vld_i = 1'b1;
        e.m0  = ref_mask(s, l, r, 3, 1, 1, 8, P0);
        e.m1  = ref_mask(s, l, r, 20, 15, 5, 6, 40);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each valid result with the queue head.
    always @(posedge clk) begin
        #1;
        if (vld0) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=unexpected result expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " u0 mask"}, vio0, e.m0);
                check({e.tag, " R8 u0 legal"}, NC'(leg0), NC'(e.m0 == '0));
                check({e.tag, " u1 mask"}, vio1, e.m1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NC-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1 vld_o", NC'(vld0), '0);
        check("R1 legal_o", NC'(leg0), NC'(1));
        check("R1 viol_o", vio0, '0);
        rst_n = 1'b1;

        drive("R3 quiet bus", 6'b00_00_00, '0, '0);
        drive("R3 middle riser", 6'b00_01_00, '0, '0);
        drive("R6 left neighbour reach", 6'b00_01_00, 6'b01_00_00, '0);
        drive("R6 right neighbour reach", 6'b00_01_00, '0, 6'b00_00_01);
        drive("R4 opposed riser", 6'b11_11_01, '0, '0);
        drive("R4 opposed faller", 6'b01_01_11, '0, '0);
        drive("R5 supply bounce", 6'b01_01_01, '0, '0);
        drive("R5 ground bounce", 6'b11_11_11, '0, '0);
        drive("R2 reserved code", 6'b10_01_10, 6'b01_00_00, '0);
        drive("R7 clamped sum", 6'b01_00_01, '0, '0);
        drive("R8 mixed mask", 6'b01_00_11, 6'b11_00_00, 6'b00_00_01);
        for (int i = 0; i < 40; i++)
            drive("R2 sweep", 6'($urandom), 6'($urandom), 6'($urandom));

        // R9: result held while no request is valid
        drive("R9 last request", 6'b01_01_01, '0, '0);
        held = ref_mask(6'b01_01_01, '0, '0, 3, 1, 1, 8, P0);
        @(negedge clk);
        vld_i = 1'b0; seg_i = 6'b00_00_00;
        repeat (3) @(negedge clk);
        check("R9 hold viol_o", vio0, held);
        check("R9 vld_o low", NC'(vld0), '0);
        check("R9 queue drained", NC'(sb.size()), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule